// File: doc/BRIEF.md
# Walsh-Domain Coefficient Arithmetic Unit

This unit combines two sets of Walsh-domain coefficients, A and B. Each set comes from its own forward transform stage, and each holds N signed coefficients in parallel. An operation code picks one of three results:

- a lane-by-lane sum, the Walsh image of the sum of the two time signals;
- a lane-by-lane difference, the image of their difference;
- the dyadic convolution, the image of their product. In the dyadic convolution, output index n pairs A at index m with B at index n XOR m.

The result vector goes on to an inverse transform and a divide-by-N stage. The unit therefore never truncates: every lane of the result is wide enough for the convolution's full range.

The sum and the difference finish in a single cycle. The convolution runs over one multiply-accumulate datapath. An internal index pair walks the summation index fastest and forms the B address by XOR. The operands are captured when the request is accepted. A one-cycle done pulse marks each new result vector. N must be a power of two, at least 2.

Top module: `walsh_coef_alu`

## Requirements
- R1: With op `2'b00` and the unit idle, a start request puts A[n]+B[n], sign-extended to RW bits, on every lane of `res_o`, with done high in the next cycle. Lane n of each vector sits at bits [n*W +: W].
- R2: With op `2'b01`, the same timing gives A[n]-B[n] on every lane.
- R3: With op `2'b10`, each lane n ends up holding the sum over m of A[m]*B[n XOR m] when done pulses.
- R4: A convolution holds `busy_o` high for exactly N*N cycles, starting in the cycle after the accepted start. `done_o` is high for one cycle, the first cycle in which busy is low again.
- R5: A start request while busy is ignored. The running convolution keeps its length and its result, and no extra done appears.
- R6: Op `2'b11` is ignored. It raises no done, no busy, and leaves `res_o` unchanged.
- R7: `res_o` changes only in a cycle where `done_o` is high and holds its value otherwise.
- R8: After reset, `busy_o` and `done_o` are low and `res_o` is zero.
- R9: Results keep full precision at the extreme coefficient values (RW = 2*CW + log2 N).
- R10: Coefficient inputs that change during a convolution do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Operation request, accepted when idle |
| op_i | input | 2 | 00 sum, 01 difference, 10 dyadic convolution, 11 none |
| coef_a_i | input | N*CW | First coefficient set, lane n at [n*CW +: CW] |
| coef_b_i | input | N*CW | Second coefficient set |
| busy_o | output | 1 | Convolution in progress |
| done_o | output | 1 | One-cycle pulse: new result on res_o |
| res_o | output | N*RW | Result vector, lane n at [n*RW +: RW] |

## Verification
Each operation gets a mixed-sign vector. With that vector, sum, difference and convolution give clearly different lane values, and a swap of A and B would show up in the difference. A convolution with asymmetric values at every index tells the XOR addressing apart from a modular-subtraction addressing. Uniform most-negative and most-positive operands probe the full-precision widths. Directed cases cover:

- a start request with fresh data arriving mid-run;
- the reserved operation code;
- holding of the result between operations.

// File: rtl/walsh_arith_pkg.sv
package walsh_arith_pkg;
  typedef enum logic [1:0] {
    OP_SUM  = 2'b00,
    OP_DIFF = 2'b01,
    OP_CONV = 2'b10,
    OP_NONE = 2'b11
  } wa_op_e;
endpackage

// File: rtl/wa_lanewise.sv
module wa_lanewise #(
  parameter int N  = 4,
  parameter int CW = 8,
  parameter int RW = 18
) (
  input  logic [N*CW-1:0] a_i,
  input  logic [N*CW-1:0] b_i,
  input  logic            sub_i,
  output logic [N*RW-1:0] res_o
);
  function automatic logic [RW-1:0] lane_op(input logic [CW-1:0] x,
                                            input logic [CW-1:0] y,
                                            input logic sub);
    logic [RW-1:0] xe;
    logic [RW-1:0] ye;
    xe = {{(RW-CW){x[CW-1]}}, x};
    ye = {{(RW-CW){y[CW-1]}}, y};
    return sub ? (xe - ye) : (xe + ye);
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign res_o[g*RW +: RW] = lane_op(a_i[g*CW +: CW], b_i[g*CW +: CW], sub_i);
  end
endmodule

// File: rtl/wa_dyadic_seq.sv
module wa_dyadic_seq #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  output logic          busy_o,
  output logic [IW-1:0] idx_n_o,
  output logic [IW-1:0] idx_m_o,
  output logic [IW-1:0] idx_b_o,
  output logic          first_o,
  output logic          row_end_o,
  output logic          last_o
);
  localparam logic [IW-1:0] IDX_MAX = IW'(N-1);

  logic          run_q;
  logic [IW-1:0] n_q;
  logic [IW-1:0] m_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      n_q   <= '0;
      m_q   <= '0;
    end else if (!run_q) begin
      n_q <= '0;
      m_q <= '0;
      if (go_i) run_q <= 1'b1;
    end else begin
      m_q <= m_q + 1'b1;
      if (m_q == IDX_MAX) n_q <= n_q + 1'b1;
      if (last_o) run_q <= 1'b0;
    end
  end

  assign busy_o    = run_q;
  assign idx_n_o   = n_q;
  assign idx_m_o   = m_q;
  assign idx_b_o   = n_q ^ m_q;
  assign first_o   = (m_q == '0);
  assign row_end_o = run_q && (m_q == IDX_MAX);
  assign last_o    = row_end_o && (n_q == IDX_MAX);
endmodule

// File: rtl/wa_mac.sv
module wa_mac #(
  parameter int N  = 4,
  parameter int CW = 8,
  parameter int RW = 18,
  localparam int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_i,
  input  logic            first_i,
  input  logic [N*CW-1:0] opa_i,
  input  logic [N*CW-1:0] opb_i,
  input  logic [IW-1:0]   idx_a_i,
  input  logic [IW-1:0]   idx_b_i,
  output logic [RW-1:0]   acc_next_o
);
  logic signed [CW-1:0] a_arr [N];
  logic signed [CW-1:0] b_arr [N];

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign a_arr[g] = opa_i[g*CW +: CW];
    assign b_arr[g] = opb_i[g*CW +: CW];
  end

  function automatic logic [RW-1:0] widen_prod(input logic signed [CW-1:0] x,
                                               input logic signed [CW-1:0] y);
    logic signed [2*CW-1:0] p;
    p = x * y;
    return {{(RW-2*CW){p[2*CW-1]}}, p};
  endfunction

  logic [RW-1:0] acc_q;
  logic [RW-1:0] term;

  assign term       = widen_prod(a_arr[idx_a_i], b_arr[idx_b_i]);
  assign acc_next_o = (first_i ? '0 : acc_q) + term;

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= '0;
    else if (step_i) acc_q <= acc_next_o;
  end
endmodule

// File: rtl/walsh_coef_alu.sv
module walsh_coef_alu
  import walsh_arith_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 8,
  localparam int IW = $clog2(N),
  localparam int RW = 2*CW + IW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic [N*CW-1:0] coef_a_i,
  input  logic [N*CW-1:0] coef_b_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [N*RW-1:0] res_o
);
  logic            busy_w;
  logic            go_conv_w;
  logic            go_ew_w;
  logic [IW-1:0]   idx_n_w;
  logic [IW-1:0]   idx_m_w;
  logic [IW-1:0]   idx_b_w;
  logic            first_w;
  logic            row_end_w;
  logic            conv_last_w;
  logic [RW-1:0]   acc_next_w;
  logic [N*RW-1:0] ew_res_w;
  logic [N*CW-1:0] opa_q;
  logic [N*CW-1:0] opb_q;
  logic [RW-1:0]   row_buf_q [N];
  logic [N*RW-1:0] res_q;
  logic            done_q;

  assign go_conv_w = start_i && !busy_w && (op_i == OP_CONV);
  assign go_ew_w   = start_i && !busy_w && ((op_i == OP_SUM) || (op_i == OP_DIFF));

  wa_lanewise #(.N(N), .CW(CW), .RW(RW)) u_lanes (
    .a_i   (coef_a_i),
    .b_i   (coef_b_i),
    .sub_i (op_i == OP_DIFF),
    .res_o (ew_res_w)
  );

  wa_dyadic_seq #(.N(N)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go_conv_w),
    .busy_o    (busy_w),
    .idx_n_o   (idx_n_w),
    .idx_m_o   (idx_m_w),
    .idx_b_o   (idx_b_w),
    .first_o   (first_w),
    .row_end_o (row_end_w),
    .last_o    (conv_last_w)
  );

  wa_mac #(.N(N), .CW(CW), .RW(RW)) u_mac (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (busy_w),
    .first_i    (first_w),
    .opa_i      (opa_q),
    .opb_i      (opb_q),
    .idx_a_i    (idx_m_w),
    .idx_b_i    (idx_b_w),
    .acc_next_o (acc_next_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
    end else if (go_conv_w) begin
      opa_q <= coef_a_i;
      opb_q <= coef_b_i;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)
        row_buf_q[g] <= '0;
      else if (row_end_w && (idx_n_w == IW'(g)))
        row_buf_q[g] <= acc_next_w;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= go_ew_w || conv_last_w;
      if (go_ew_w) begin
        res_q <= ew_res_w;
      end else if (conv_last_w) begin
        for (int i = 0; i < N-1; i++) res_q[i*RW +: RW] <= row_buf_q[i];
        res_q[(N-1)*RW +: RW] <= acc_next_w;
      end
    end
  end

  assign busy_o = busy_w;
  assign done_o = done_q;
  assign res_o  = res_q;
endmodule

// File: rtl/walsh_coef_alu_chk.sv
module walsh_coef_alu_chk #(
  parameter int N  = 4,
  parameter int RW = 18,
  localparam int IW = $clog2(N)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [1:0]      op_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [N*RW-1:0] res_o,
  input logic [IW-1:0]   idx_n,
  input logic [IW-1:0]   idx_m,
  input logic            conv_last
);
  localparam logic [IW-1:0] IDX_MAX = IW'(N-1);
  logic [31:0] busy_len_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      busy_len_q <= '0;
    else if (busy_o) busy_len_q <= busy_len_q + 1'b1;
    else             busy_len_q <= '0;
  end

  // R1
  ew_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !op_i[1]) |=> (done_o && !busy_o));

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_len_q == 32'(N*N) && done_o));

  // R4
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(start_i) && $past(op_i) == 2'b10));

  // R3
  index_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && idx_m == IDX_MAX && !conv_last) |=>
      (idx_m == '0 && idx_n == $past(idx_n) + 1'b1));

  // R5
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !conv_last) |=> (busy_o && !done_o));

  // R6
  null_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && op_i == 2'b11) |=> (!done_o && !busy_o));

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(res_o));
endmodule

bind walsh_coef_alu walsh_coef_alu_chk #(.N(N), .RW(RW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .op_i      (op_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .res_o     (res_o),
  .idx_n     (idx_n_w),
  .idx_m     (idx_m_w),
  .conv_last (conv_last_w)
);

// File: tb/walsh_coef_alu_test.sv
module walsh_coef_alu_test;
  localparam int N  = 4;
  localparam int CW = 8;
  localparam int RW = 2*CW + 2;
  localparam int NV = 7;

  localparam logic [1:0]      T_OP [NV] = '{2'b00, 2'b01, 2'b10, 2'b10, 2'b00, 2'b01, 2'b10};
  localparam logic [N*CW-1:0] T_A  [NV] = '{32'h0703FEFA, 32'h0703FEFA, 32'h0703FEFA,
                                            32'h80808080, 32'h7F7F7F7F, 32'h7F808000, 32'h7F808000};
  localparam logic [N*CW-1:0] T_B  [NV] = '{32'h04030201, 32'h04030201, 32'h04030201,
                                            32'h80808080, 32'h7F7F7F7F, 32'h807F0180, 32'h807F0180};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [1:0]      op_i = 2'b00;
  logic [N*CW-1:0] coef_a_i = '0;
  logic [N*CW-1:0] coef_b_i = '0;
  logic            busy_o;
  logic            done_o;
  logic [N*RW-1:0] res_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  walsh_coef_alu #(.N(N), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .coef_a_i(coef_a_i), .coef_b_i(coef_b_i),
    .busy_o(busy_o), .done_o(done_o), .res_o(res_o)
  );

  function automatic int coef(input logic [N*CW-1:0] v, input int i);
    return int'($signed(v[i*CW +: CW]));
  endfunction

  // Bench model: convolution written as sum over k of A[n^k]*B[k]
  function automatic int model(input logic [1:0] op, input logic [N*CW-1:0] a,
                               input logic [N*CW-1:0] b, input int n);
    int s;
    s = 0;
    case (op)
      2'b00: s = coef(a, n) + coef(b, n);
      2'b01: s = coef(a, n) - coef(b, n);
      default: for (int k = 0; k < N; k++) s += coef(a, n ^ k) * coef(b, k);
    endcase
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_lanes(input string tag, input logic [1:0] op,
                             input logic [N*CW-1:0] a, input logic [N*CW-1:0] b);
    for (int i = 0; i < N; i++) begin
      int e;
      logic [RW-1:0] eb;
      e  = model(op, a, b, i);
      eb = RW'(e);
      check(res_o[i*RW +: RW] == eb, tag, int'($signed(res_o[i*RW +: RW])), e);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [N*CW-1:0] a, input logic [N*CW-1:0] b);
    op_i = op; coef_a_i = a; coef_b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // returns number of busy cycles seen before done
  task automatic wait_done(output int busy_len, output bit saw_done);
    busy_len = 0;
    saw_done = 1'b0;
    while (busy_o && busy_len < 1000) begin
      busy_len++;
      @(negedge clk);
    end
    saw_done = done_o;
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int blen;
    bit sd;
    logic [N*RW-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(busy_o == 1'b0, "R8 busy", int'(busy_o), 0);
    check(done_o == 1'b0, "R8 done", int'(done_o), 0);
    check(res_o == '0, "R8 res", int'(res_o != '0), 0);

    // table walk: R1 R2 R3 R4 R9
    for (int v = 0; v < NV; v++) begin
      issue(T_OP[v], T_A[v], T_B[v]);
      if (T_OP[v] == 2'b10) begin
        wait_done(blen, sd);
        check(blen == N*N, "R4 busy length", blen, N*N);
        check(sd, "R4 done after busy", int'(sd), 1);
        check_lanes("R3 convolution", T_OP[v], T_A[v], T_B[v]);
      end else begin
        check(done_o && !busy_o, "R1 one-cycle done", int'(done_o), 1);
        check_lanes(T_OP[v] == 2'b00 ? "R1 sum" : "R2 difference", T_OP[v], T_A[v], T_B[v]);
      end
      @(negedge clk);
      check(!done_o, "R4 done single pulse", int'(done_o), 0);
    end

    // R9 extremes: -128*-128*4 and 127+127
    issue(2'b10, 32'h80808080, 32'h80808080);
    wait_done(blen, sd);
    check($signed(res_o[0 +: RW]) == 65536, "R9 conv extreme", int'($signed(res_o[0 +: RW])), 65536);

    // R5 R10: start and new inputs mid-run are ignored
    issue(2'b10, T_A[6], T_B[6]);
    repeat (3) @(negedge clk);
    op_i = 2'b00; coef_a_i = 32'h11223344; coef_b_i = 32'h55667788; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o && !done_o, "R5 no early done", int'(done_o), 0);
    wait_done(blen, sd);
    check(blen == N*N - 4, "R5 busy length kept", blen, N*N - 4);
    check(sd, "R5 single done", int'(sd), 1);
    check_lanes("R10 captured operands", 2'b10, T_A[6], T_B[6]);

    // R7 hold
    held = res_o;
    repeat (5) @(negedge clk);
    check(res_o == held, "R7 hold", int'(res_o != held), 0);

    // R6 reserved op
    issue(2'b11, 32'h01010101, 32'h01010101);
    check(!done_o && !busy_o, "R6 no done", int'(done_o), 0);
    @(negedge clk);
    check(res_o == held, "R6 res unchanged", int'(res_o != held), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule